// File: doc/BRIEF.md
# Dual-Direction Audio Sample FIFO with Threshold DMA and Interrupts

This block sits between a register bus and a serial audio shifter. It holds two independent sample queues. The playback queue is loaded by the bus and emptied by the shifter. The capture queue is loaded by the shifter and emptied by the bus. Each queue reports its occupancy and four level flags. Each queue compares its occupancy against a programmable threshold and raises a DMA request, which lets a DMA engine keep the playback queue topped up and the capture queue drained.

Errors are recorded in sticky status bits: a pop from an empty queue (starve) or a push into a full queue (overflow). The level conditions and a word-transfer event feed the same status vector. A per-bit enable mask, a global enable and a clear strobe with a bit mask turn that vector into a single registered interrupt line. Serial shifting and clock generation belong to neighbouring blocks.

Top module: `audfifo_top`

## Requirements
- R1: Samples are 16 bits wide and leave each queue in the order they entered. A bus read of the capture queue presents the sample on `rx_rdata[15:0]` in the cycle after the read strobe, with `rx_rdata[16]` = 1. The playback queue presents its sample on `ser_tx_data` in the same way, with `ser_tx_valid` = 1.
- R2: Each queue has a 6-bit occupancy count, 0 to 32 at the default depth. The count changes in the cycle after an accepted push or pop. A push and a pop that are both accepted in the same cycle leave the count unchanged.
- R3: The level flags are bit 0 empty (count = 0), bit 1 almost-empty (count ≤ 2), bit 2 full (count = 32) and bit 3 almost-full (count ≥ 30). They follow the count with no extra delay.
- R4: A push into a full queue is dropped. It leaves the count and the stored data untouched and sets that direction's overflow status bit.
- R5: A pop from an empty queue returns valid = 0. It leaves the pointers untouched and sets that direction's starve status bit.
- R6: While a direction's queue enable is low, its count is forced to 0 from the next edge. Pushes and pops in that direction are then ignored and raise no error bits.
- R7: `tx_dma_req` is high when the playback DMA enable and queue enable are both set and the playback count ≤ `tx_thresh`. `rx_dma_req` is high when both capture enables are set and the capture count ≥ `rx_thresh`.
- R8: `irq_status` bit layout: bits 3:0 are the playback level flags (R3 order), bit 4 is playback starve, bit 5 is playback overflow, bits 9:6 are the capture level flags, bit 10 is capture starve, bit 11 is capture overflow, and bit 12 is the word-transfer bit. Level bits are live copies of the flags.
- R9: The word-transfer bit is set by an accepted bus push into the playback queue or by a successful bus pop from the capture queue. It is sticky.
- R10: When `clr_wr` is high, the sticky bits (4, 5, 10, 11, 12) selected by `clr_mask` clear at the next edge. An event in the same cycle wins over the clear. Mask bits on level positions have no effect.
- R11: `irq_pending` is the OR of `irq_status[11:0] & cond_en` and `irq_status[12] & xfer_en`. `irq` is a register loaded with `irq_pending & irq_global_en`, so it follows one cycle later.
- R12: After reset both counts are 0, all sticky bits are 0, both valid outputs are 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_fifo_en | input | 1 | Playback queue enable |
| rx_fifo_en | input | 1 | Capture queue enable |
| tx_dma_en | input | 1 | Playback DMA request enable |
| rx_dma_en | input | 1 | Capture DMA request enable |
| tx_thresh | input | 6 | Playback request level |
| rx_thresh | input | 6 | Capture request level |
| tx_wr | input | 1 | Bus push strobe into playback queue |
| tx_wdata | input | 16 | Bus sample to push |
| ser_tx_rd | input | 1 | Shifter pop strobe from playback queue |
| ser_tx_data | output | 16 | Sample popped by the shifter |
| ser_tx_valid | output | 1 | Shifter pop returned a sample |
| ser_rx_wr | input | 1 | Shifter push strobe into capture queue |
| ser_rx_data | input | 16 | Captured sample |
| rx_rd | input | 1 | Bus pop strobe from capture queue |
| rx_rdata | output | 17 | Bit 16 valid, bits 15:0 sample |
| tx_count | output | 6 | Playback occupancy |
| rx_count | output | 6 | Capture occupancy |
| tx_level | output | 4 | Playback level flags |
| rx_level | output | 4 | Capture level flags |
| tx_dma_req | output | 1 | Playback DMA request |
| rx_dma_req | output | 1 | Capture DMA request |
| cond_en | input | 12 | Enables for status bits 11:0 |
| xfer_en | input | 1 | Enable for the word-transfer bit |
| irq_global_en | input | 1 | Global interrupt enable |
| clr_wr | input | 1 | Clear strobe |
| clr_mask | input | 13 | Status bits to clear |
| irq_status | output | 13 | Status vector |
| irq_pending | output | 1 | An enabled status bit is set |
| irq | output | 1 | Registered interrupt |

## Verification
Two functions can meet in the same cycle. A clear of a sticky bit can coincide with a new overflow, starve or word-transfer event that sets the same bit. A push and a pop can also hit one queue at once while it is full or empty. The directed part of the bench drives a clear with a full mask while pushing into a full queue. The random part issues clears often enough that they overlap traffic many times. A reference model in the bench applies "event wins over clear" and "level checked before the cycle's traffic", and every output is compared against it on each falling edge.

// File: rtl/audfifo_pkg.sv
package audfifo_pkg;
  // per-direction status slice layout
  localparam int SL_EMPTY  = 0;
  localparam int SL_AEMPTY = 1;
  localparam int SL_FULL   = 2;
  localparam int SL_AFULL  = 3;
  localparam int SL_STARVE = 4;
  localparam int SL_OVFL   = 5;
  localparam int SLICE_W   = 6;
  localparam int LVL_W     = 4;
  localparam int NDIR      = 2;
  localparam int DIR_TX    = 0;
  localparam int DIR_RX    = 1;
  localparam int NCOND     = NDIR * SLICE_W;
  localparam int STAT_W    = NCOND + 1;
endpackage

// File: rtl/audfifo_ram.sv
module audfifo_ram #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/audfifo_chan.sv
module audfifo_chan #(
  parameter int DEPTH  = 32,
  parameter int WIDTH  = 16,
  parameter int MARGIN = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            en,
  input  logic                            push,
  input  logic [WIDTH-1:0]                push_data,
  input  logic                            pop,
  output logic [WIDTH-1:0]                pop_data,
  output logic                            pop_valid,
  output logic [CW-1:0]                   count,
  output logic [audfifo_pkg::LVL_W-1:0]   level,
  output logic                            push_ok,
  output logic                            pop_ok,
  output logic                            ovf_evt,
  output logic                            stv_evt
);
  import audfifo_pkg::*;

  logic [AW-1:0] wptr, rptr;
  logic is_full, is_empty;

  assign is_full  = (count == CW'(DEPTH));
  assign is_empty = (count == '0);

  assign push_ok = en & push & ~is_full;
  assign pop_ok  = en & pop  & ~is_empty;
  assign ovf_evt = en & push & is_full;
  assign stv_evt = en & pop  & is_empty;

  assign level[SL_EMPTY]  = is_empty;
  assign level[SL_AEMPTY] = (count <= CW'(MARGIN));
  assign level[SL_FULL]   = is_full;
  assign level[SL_AFULL]  = (count >= CW'(DEPTH - MARGIN));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= wptr + 1'b1;
      if (pop_ok)  rptr <= rptr + 1'b1;
      unique case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pop_valid <= 1'b0;
    else     pop_valid <= pop_ok;
  end

  audfifo_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ram (
    .clk   (clk),
    .we    (push_ok),
    .waddr (wptr),
    .wdata (push_data),
    .re    (pop_ok),
    .raddr (rptr),
    .rdata (pop_data)
  );
endmodule

// File: rtl/audfifo_irq.sv
module audfifo_irq
  import audfifo_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NDIR-1:0][LVL_W-1:0] lvl,
  input  logic [NDIR-1:0]            stv_evt,
  input  logic [NDIR-1:0]            ovf_evt,
  input  logic                       xfer_evt,
  input  logic                       clr_wr,
  input  logic [STAT_W-1:0]          clr_mask,
  input  logic [NCOND-1:0]           cond_en,
  input  logic                       xfer_en,
  input  logic                       glob_en,
  output logic [STAT_W-1:0]          status,
  output logic                       pending,
  output logic                       irq
);
  logic [STAT_W-1:0] clr_v;
  logic              xfer_q;

  assign clr_v = clr_wr ? clr_mask : '0;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    localparam int B = d * SLICE_W;
    logic stv_q, ovf_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        stv_q <= 1'b0;
        ovf_q <= 1'b0;
      end else begin
        stv_q <= (stv_q & ~clr_v[B + SL_STARVE]) | stv_evt[d];
        ovf_q <= (ovf_q & ~clr_v[B + SL_OVFL])   | ovf_evt[d];
      end
    end

    assign status[B +: LVL_W]     = lvl[d];
    assign status[B + SL_STARVE]  = stv_q;
    assign status[B + SL_OVFL]    = ovf_q;
  end

  always_ff @(posedge clk) begin
    if (rst) xfer_q <= 1'b0;
    else     xfer_q <= (xfer_q & ~clr_v[NCOND]) | xfer_evt;
  end
  assign status[NCOND] = xfer_q;

  assign pending = (|(status[NCOND-1:0] & cond_en)) | (status[NCOND] & xfer_en);

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= pending & glob_en;
  end
endmodule

// File: rtl/audfifo_top.sv
module audfifo_top #(
  parameter int DEPTH  = 32,
  parameter int WIDTH  = 16,
  parameter int MARGIN = 2,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int NC = audfifo_pkg::NCOND,
  localparam int SW = audfifo_pkg::STAT_W,
  localparam int LW = audfifo_pkg::LVL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_fifo_en,
  input  logic             rx_fifo_en,
  input  logic             tx_dma_en,
  input  logic             rx_dma_en,
  input  logic [CW-1:0]    tx_thresh,
  input  logic [CW-1:0]    rx_thresh,
  input  logic             tx_wr,
  input  logic [WIDTH-1:0] tx_wdata,
  input  logic             ser_tx_rd,
  output logic [WIDTH-1:0] ser_tx_data,
  output logic             ser_tx_valid,
  input  logic             ser_rx_wr,
  input  logic [WIDTH-1:0] ser_rx_data,
  input  logic             rx_rd,
  output logic [WIDTH:0]   rx_rdata,
  output logic [CW-1:0]    tx_count,
  output logic [CW-1:0]    rx_count,
  output logic [LW-1:0]    tx_level,
  output logic [LW-1:0]    rx_level,
  output logic             tx_dma_req,
  output logic             rx_dma_req,
  input  logic [NC-1:0]    cond_en,
  input  logic             xfer_en,
  input  logic             irq_global_en,
  input  logic             clr_wr,
  input  logic [SW-1:0]    clr_mask,
  output logic [SW-1:0]    irq_status,
  output logic             irq_pending,
  output logic             irq
);
  import audfifo_pkg::*;

  logic tx_push_ok, tx_pop_ok, tx_ovf, tx_stv;
  logic rx_push_ok, rx_pop_ok, rx_ovf, rx_stv;
  logic rx_vld;
  logic [WIDTH-1:0] rx_dat;

  audfifo_chan #(.DEPTH(DEPTH), .WIDTH(WIDTH), .MARGIN(MARGIN)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .en        (tx_fifo_en),
    .push      (tx_wr),
    .push_data (tx_wdata),
    .pop       (ser_tx_rd),
    .pop_data  (ser_tx_data),
    .pop_valid (ser_tx_valid),
    .count     (tx_count),
    .level     (tx_level),
    .push_ok   (tx_push_ok),
    .pop_ok    (tx_pop_ok),
    .ovf_evt   (tx_ovf),
    .stv_evt   (tx_stv)
  );

  audfifo_chan #(.DEPTH(DEPTH), .WIDTH(WIDTH), .MARGIN(MARGIN)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .en        (rx_fifo_en),
    .push      (ser_rx_wr),
    .push_data (ser_rx_data),
    .pop       (rx_rd),
    .pop_data  (rx_dat),
    .pop_valid (rx_vld),
    .count     (rx_count),
    .level     (rx_level),
    .push_ok   (rx_push_ok),
    .pop_ok    (rx_pop_ok),
    .ovf_evt   (rx_ovf),
    .stv_evt   (rx_stv)
  );

  assign rx_rdata = {rx_vld, rx_dat};

  assign tx_dma_req = tx_dma_en & tx_fifo_en & (tx_count <= tx_thresh);
  assign rx_dma_req = rx_dma_en & rx_fifo_en & (rx_count >= rx_thresh);

  audfifo_irq u_irq (
    .clk      (clk),
    .rst      (rst),
    .lvl      ({rx_level, tx_level}),
    .stv_evt  ({rx_stv, tx_stv}),
    .ovf_evt  ({rx_ovf, tx_ovf}),
    .xfer_evt (tx_push_ok | rx_pop_ok),
    .clr_wr   (clr_wr),
    .clr_mask (clr_mask),
    .cond_en  (cond_en),
    .xfer_en  (xfer_en),
    .glob_en  (irq_global_en),
    .status   (irq_status),
    .pending  (irq_pending),
    .irq      (irq)
  );
endmodule

// File: rtl/audfifo_chk.sv
module audfifo_chk #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 16,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int NC = audfifo_pkg::NCOND,
  localparam int SW = audfifo_pkg::STAT_W,
  localparam int LW = audfifo_pkg::LVL_W
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_fifo_en,
  input logic             rx_fifo_en,
  input logic             tx_wr,
  input logic             ser_tx_rd,
  input logic             ser_rx_wr,
  input logic             rx_rd,
  input logic [WIDTH:0]   rx_rdata,
  input logic [CW-1:0]    tx_count,
  input logic [CW-1:0]    rx_count,
  input logic [LW-1:0]    tx_level,
  input logic [LW-1:0]    rx_level,
  input logic             irq_global_en,
  input logic             clr_wr,
  input logic [SW-1:0]    clr_mask,
  input logic [SW-1:0]    irq_status,
  input logic             irq_pending,
  input logic             irq
);
  a_r2_count_bounded: assert property (@(posedge clk) disable iff (rst)
    (tx_count <= CW'(DEPTH)) && (rx_count <= CW'(DEPTH)));

  a_r3_full_not_empty: assert property (@(posedge clk) disable iff (rst)
    !(tx_level[2] && tx_level[0]) && !(rx_level[2] && rx_level[0]));

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (tx_fifo_en && tx_level[2] && tx_wr && !ser_tx_rd) |=> $stable(tx_count));

  a_r4_ovfl_sticky: assert property (@(posedge clk) disable iff (rst)
    (rx_fifo_en && rx_level[2] && ser_rx_wr) |=> irq_status[11]);

  a_r5_starve_flag: assert property (@(posedge clk) disable iff (rst)
    (rx_fifo_en && rx_level[0] && rx_rd) |=> (irq_status[10] && !rx_rdata[WIDTH]));

  a_r1_valid_after_read: assert property (@(posedge clk) disable iff (rst)
    rx_rdata[WIDTH] |-> $past(rx_rd));

  a_r6_disable_flush: assert property (@(posedge clk) disable iff (rst)
    !tx_fifo_en |=> (tx_count == '0));

  a_r10_clear_wins_alone: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && clr_mask[4] && !(tx_fifo_en && ser_tx_rd && tx_level[0]))
      |=> !irq_status[4]);

  a_r11_irq_follows: assert property (@(posedge clk) disable iff (rst)
    (irq_pending && irq_global_en) |=> irq);

  a_r11_irq_gated: assert property (@(posedge clk) disable iff (rst)
    !irq_global_en |=> !irq);
endmodule

bind audfifo_top audfifo_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (.*);

// File: tb/tb_audfifo_top.sv
module tb_audfifo_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;
  localparam int M = 2;
  localparam int CW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_fifo_en = 0, rx_fifo_en = 0, tx_dma_en = 0, rx_dma_en = 0;
  logic [CW-1:0] tx_thresh = 6'd4, rx_thresh = 6'd32;
  logic tx_wr = 0, ser_tx_rd = 0, ser_rx_wr = 0, rx_rd = 0;
  logic [15:0] tx_wdata = 0, ser_rx_data = 0;
  logic [15:0] ser_tx_data;
  logic ser_tx_valid;
  logic [16:0] rx_rdata;
  logic [CW-1:0] tx_count, rx_count;
  logic [3:0] tx_level, rx_level;
  logic tx_dma_req, rx_dma_req;
  logic [11:0] cond_en = 0;
  logic xfer_en = 0, irq_global_en = 0, clr_wr = 0;
  logic [12:0] clr_mask = 0;
  logic [12:0] irq_status;
  logic irq_pending, irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  audfifo_top dut (.*);

  int n_vec = 0, n_bad = 0;
  bit started = 0, finished = 0;
  int p_txw = 0, p_txr = 0, p_rxw = 0, p_rxr = 0, p_clr = 0;

  // reference model
  logic [15:0] txq[$], rxq[$];
  logic [12:0] m_stk;
  logic m_txv, m_rxv, m_irq;
  logic [15:0] m_txd, m_rxd;
  logic [12:0] m_ev, m_st;
  int ts, rs;
  localparam logic [12:0] STICKY = 13'b1_1100_0011_0000;

  function automatic logic [3:0] lvl4(int n);
    return {n >= DEPTH - M, n == DEPTH, n <= M, n == 0};
  endfunction

  function automatic logic [12:0] stat_of(int t, int r, logic [12:0] stk);
    logic [12:0] s;
    s = stk & STICKY;
    s[3:0] = lvl4(t);
    s[9:6] = lvl4(r);
    return s;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      txq.delete(); rxq.delete();
      m_stk = 0; m_txv = 0; m_rxv = 0; m_irq = 0;
      started = 1;
    end else begin
      ts = txq.size(); rs = rxq.size();
      m_st = stat_of(ts, rs, m_stk);
      m_irq = irq_global_en && ((|(m_st[11:0] & cond_en)) || (m_st[12] && xfer_en));
      m_ev = 0;
      m_txv = 0; m_rxv = 0;
      if (tx_fifo_en) begin
        m_ev[4] = ser_tx_rd && ts == 0;
        m_ev[5] = tx_wr && ts == DEPTH;
        if (ser_tx_rd && ts > 0) begin m_txv = 1; m_txd = txq.pop_front(); end
        if (tx_wr && ts < DEPTH) begin txq.push_back(tx_wdata); m_ev[12] = 1; end
      end else txq.delete();
      if (rx_fifo_en) begin
        m_ev[10] = rx_rd && rs == 0;
        m_ev[11] = ser_rx_wr && rs == DEPTH;
        if (rx_rd && rs > 0) begin m_rxv = 1; m_rxd = rxq.pop_front(); m_ev[12] = 1; end
        if (ser_rx_wr && rs < DEPTH) rxq.push_back(ser_rx_data);
      end else rxq.delete();
      m_stk = ((m_stk & ~(clr_wr ? clr_mask : 13'd0)) | m_ev) & STICKY;
    end
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    logic [12:0] st;
    logic pend;
    st = stat_of(txq.size(), rxq.size(), m_stk);
    pend = (|(st[11:0] & cond_en)) || (st[12] && xfer_en);
    chk("R2", "tx_count", tx_count, txq.size());
    chk("R2", "rx_count", rx_count, rxq.size());
    chk("R3", "tx_level", tx_level, lvl4(txq.size()));
    chk("R3", "rx_level", rx_level, lvl4(rxq.size()));
    chk("R7", "tx_dma_req", tx_dma_req, tx_dma_en && tx_fifo_en && (txq.size() <= int'(tx_thresh)));
    chk("R7", "rx_dma_req", rx_dma_req, rx_dma_en && rx_fifo_en && (rxq.size() >= int'(rx_thresh)));
    chk("R8", "irq_status", irq_status, st);
    chk("R11", "irq_pending", irq_pending, pend);
    chk("R11", "irq", irq, m_irq);
    chk("R1", "ser_tx_valid", ser_tx_valid, m_txv);
    chk("R5", "rx_valid", rx_rdata[16], m_rxv);
    if (m_txv) chk("R1", "ser_tx_data", ser_tx_data, m_txd);
    if (m_rxv) chk("R1", "rx_data", rx_rdata[15:0], m_rxd);
  endtask

  function automatic bit pct(int p);
    return $urandom_range(0, 99) < p;
  endfunction

  task automatic step();
    @(negedge clk);
    if (started && !rst) check_all();
    tx_wr = pct(p_txw); tx_wdata = 16'($urandom);
    ser_tx_rd = pct(p_txr);
    ser_rx_wr = pct(p_rxw); ser_rx_data = 16'($urandom);
    rx_rd = pct(p_rxr);
    clr_wr = pct(p_clr);
    clr_mask = 13'($urandom);
  endtask

  task automatic run(int n, int a, int b, int c, int d, int e);
    p_txw = a; p_txr = b; p_rxw = c; p_rxr = d; p_clr = e;
    repeat (n) step();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12: reset state
    chk("R12", "tx_count after reset", tx_count, 0);
    chk("R12", "rx_count after reset", rx_count, 0);
    chk("R12", "sticky after reset", irq_status & STICKY, 0);
    chk("R12", "irq after reset", irq, 0);
    chk("R12", "valids after reset", {ser_tx_valid, rx_rdata[16]}, 0);
    // R6: disabled queues ignore traffic
    run(6, 100, 50, 100, 50, 0);
    tx_fifo_en = 1; rx_fifo_en = 1; tx_dma_en = 1; rx_dma_en = 1;
    cond_en = 12'hfff; xfer_en = 1; irq_global_en = 1;
    // R4, R3, R7: fill past full (overflow)
    run(38, 100, 0, 100, 0, 0);
    // R10: clear overlapping an overflow event, event wins
    p_clr = 100; @(negedge clk); check_all();
    tx_wr = 1; ser_rx_wr = 1; clr_wr = 1; clr_mask = 13'h1fff;
    step();
    run(2, 0, 0, 0, 0, 0);
    // R5, R1: drain past empty (starve), order check on data
    run(38, 0, 100, 0, 100, 0);
    // R10: plain clear of everything
    @(negedge clk); check_all();
    clr_wr = 1; clr_mask = 13'h1fff; tx_wr = 0; ser_tx_rd = 0; ser_rx_wr = 0; rx_rd = 0;
    run(3, 0, 0, 0, 0, 0);
    // R2: simultaneous push/pop at mid level
    run(10, 100, 0, 100, 0, 0);
    run(20, 100, 100, 100, 100, 0);
    // R9: word transfer under masked interrupts, R11 gating
    cond_en = 0; irq_global_en = 0;
    run(20, 50, 50, 50, 50, 10);
    // random phase
    for (int blk = 0; blk < 30; blk++) begin
      tx_thresh = 6'($urandom_range(0, 34));
      rx_thresh = 6'($urandom_range(0, 34));
      cond_en = 12'($urandom);
      xfer_en = 1'($urandom);
      irq_global_en = pct(70);
      tx_fifo_en = pct(90); rx_fifo_en = pct(90);
      tx_dma_en = pct(80); rx_dma_en = pct(80);
      run(100, $urandom_range(20, 80), $urandom_range(20, 80),
          $urandom_range(20, 80), $urandom_range(20, 80), 8);
    end
    // R6: disable flush with traffic present
    tx_fifo_en = 1; rx_fifo_en = 1;
    run(20, 100, 0, 100, 0, 0);
    tx_fifo_en = 0; rx_fifo_en = 0;
    run(5, 100, 100, 100, 100, 0);
    @(negedge clk);
    chk("R6", "tx_count disabled", tx_count, 0);
    chk("R6", "rx_count disabled", rx_count, 0);
    // R9 final
    chk("R9", "xfer bit tracked", irq_status[12], m_stk[12]);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R12 watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule